// File: doc/BRIEF.md
# Three-Axis Result Hold and Ready Flag

This block sits between a measurement sequencer and the register read path of a three-axis field sensor. It keeps the six result bytes (two per axis) that the host reads. A new 48-bit result arrives with a one-cycle write strobe. Each byte has its own read strobe. Once the host has read some of the six bytes but not all of them, the block holds the whole set. No newer result can then mix halves of two different measurements. A result that arrives during the hold is discarded, and the sequencer sees a one-cycle lost pulse.

The block also drives the ready flag. The flag drops when a result is loaded. It rises again only after a guaranteed minimum low time, which is derived from the clock frequency so that the flag is never low for less than 5 us. The flag stays high until the host has read all six bytes or a new result replaces the set. An off-state input forces the flag low. The flag, the hold indication and a regulator-enabled input are packed into a status byte, and the flag is also driven on a dedicated ready pin.

Top module: `mag_result_guard`

## Requirements
- R1: After reset, all result bytes are zero, the status byte is 0x00, and both the ready pin and the lost pulse are low.
- R2: Byte k of the result is `result_o[8k+7:8k]` and is read by strobe bit k. When a read leaves some, but not all, bytes read since the last unlock, the hold flag (status bit 1) is high from the next cycle.
- R3: While the hold flag is high and no mode or configuration change pulse is present, a write strobe leaves `result_o` unchanged. `lost_o` is then high for exactly the one cycle after the strobe.
- R4: The hold flag clears when every byte has been read at least once, in any order and over any number of cycles; repeated reads of the same byte count once. A `mode_chg_i` or `meas_chg_i` pulse also clears it. A write in the same cycle as such a pulse is accepted.
- R5: A write strobe that is accepted shows its data on `result_o` in the next cycle and clears RDY at the same edge. Read strobes in that cycle belong to the old data and are not counted.
- R6: With MIN = ceil(CLK_FREQ_HZ x 5 us) cycles, RDY rises exactly MIN+1 cycles after the edge that accepted a write. RDY is never low for fewer than MIN cycles before rising.
- R7: Once high, RDY stays high until all six bytes have been read or a new result is accepted. A completed full read clears RDY in the next cycle and cancels a rise that has not happened yet.
- R8: While `off_mode_i` is high, RDY is low and any pending rise is cancelled. A result loaded during the off state does not raise RDY later.
- R9: The status byte carries RDY in bit 0, the hold flag in bit 1 and `ren_i` in bit 2, with bits 7 to 3 zero. `drdy_o` always equals status bit 0.
- R10: A write that falls in the same cycle as the read that completes the set is dropped, because the hold is judged before that cycle's reads. The hold flag still clears after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_strobe_i | input | 1 | New result write strobe from the sequencer |
| wr_data_i | input | 48 | New result, byte k in bits 8k+7:8k |
| rd_strobe_i | input | 6 | Per-byte read strobes from the register path |
| mode_chg_i | input | 1 | Operating-mode change pulse |
| meas_chg_i | input | 1 | Measurement-configuration change pulse |
| off_mode_i | input | 1 | Off state, holds RDY low |
| ren_i | input | 1 | Regulator-enabled level shown in the status byte |
| result_o | output | 48 | Visible result bytes |
| status_o | output | 8 | Status byte: RDY, hold flag, regulator enable |
| drdy_o | output | 1 | Ready pin, mirrors RDY |
| lost_o | output | 1 | One-cycle pulse when a result was dropped |

## Verification
Some events can fall in the same cycle, and those cycles are the risky ones. The main case is a result write that arrives in the cycle whose read strobes complete the set. The bench provokes it in half of a sweep over all 62 proper read subsets: it drives the complementary strobes together with a write. It expects the old data to remain, the lost pulse to fire and the hold flag to clear. A write that coincides with a configuration-change pulse is provoked as well, and it must be accepted with no lost pulse.

// File: rtl/rgd_pkg.sv
package rgd_pkg;
    // Width of one visible result byte.
    localparam int unsigned BYTE_W = 8;
    // Status byte bit positions (host software decodes these).
    localparam int unsigned ST_READY_BIT = 0;
    localparam int unsigned ST_HOLD_BIT  = 1;
    localparam int unsigned ST_REG_BIT   = 2;
    // Status byte width.
    localparam int unsigned ST_W = 8;
endpackage

// File: rtl/rgd_read_tracker.sv
module rgd_read_tracker #(
    parameter int unsigned N_BYTES = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_req_i,
    input  logic [N_BYTES-1:0] rd_hit_i,
    input  logic               cfg_change_i,
    output logic               accept_o,
    output logic               set_done_o,
    output logic               locked_o,
    output logic               lost_o
);
    localparam logic [N_BYTES-1:0] ALL_READ = {N_BYTES{1'b1}};

    typedef struct packed {
        logic [N_BYTES-1:0] seen;
        logic               lost;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [N_BYTES-1:0] seen_merge;

    always_comb begin
        trk_d      = trk_q;
        seen_merge = trk_q.seen | rd_hit_i;
        // Hold is judged on the registered read set: reads of this cycle
        // cannot release a write that arrives in the same cycle.
        accept_o   = wr_req_i && ((trk_q.seen == '0) || cfg_change_i);
        set_done_o = 1'b0;
        trk_d.lost = wr_req_i && !accept_o;
        if (cfg_change_i || accept_o) begin
            trk_d.seen = '0;
        end else if (seen_merge == ALL_READ) begin
            trk_d.seen = '0;
            set_done_o = 1'b1;
        end else begin
            trk_d.seen = seen_merge;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign locked_o = (trk_q.seen != '0);
    assign lost_o   = trk_q.lost;

    // R4: a completed read set leaves the block unlocked.
    p_done_unlocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_done_o |=> !locked_o);

    // R2: a partial read with no release event locks the set.
    p_partial_locks_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_req_i && !cfg_change_i && (rd_hit_i != '0) && !set_done_o) |=> locked_o);

endmodule

// File: rtl/rgd_ready_timer.sv
module rgd_ready_timer #(
    parameter int unsigned HOLD_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic drop_i,
    input  logic off_i,
    output logic rdy_o
);
    localparam int unsigned        CNT_W  = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0]   HOLD_W = CNT_W'(HOLD_CYC);

    typedef struct packed {
        logic             rdy;
        logic             pending;
        logic [CNT_W-1:0] low_cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (off_i) begin
            tmr_d.rdy     = 1'b0;
            tmr_d.pending = 1'b0;
            tmr_d.low_cnt = '0;
        end else if (load_i) begin
            tmr_d.rdy     = 1'b0;
            tmr_d.pending = 1'b1;
            tmr_d.low_cnt = '0;
        end else if (drop_i) begin
            tmr_d.rdy     = 1'b0;
            tmr_d.pending = 1'b0;
            tmr_d.low_cnt = '0;
        end else begin
            if (!tmr_q.rdy && (tmr_q.low_cnt != HOLD_W)) begin
                tmr_d.low_cnt = tmr_q.low_cnt + 1'b1;
            end
            if (tmr_q.pending && (tmr_q.low_cnt == HOLD_W)) begin
                tmr_d.rdy     = 1'b1;
                tmr_d.pending = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q.rdy     <= 1'b0;
            tmr_q.pending <= 1'b0;
            tmr_q.low_cnt <= HOLD_W;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign rdy_o = tmr_q.rdy;

    // R8: the off state forces the flag low on the following cycle.
    p_off_forces_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        off_i |=> !rdy_o);

    // R7: the flag only falls because of a load, a full read or the off state.
    p_fall_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_o && !load_i && !drop_i && !off_i) |=> rdy_o);

endmodule

// File: rtl/rgd_result_store.sv
module rgd_result_store
    import rgd_pkg::*;
#(
    parameter int unsigned N_BYTES = 6
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        load_i,
    input  logic [N_BYTES*BYTE_W-1:0]   data_i,
    output logic [N_BYTES*BYTE_W-1:0]   bytes_o
);
    for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_d, lane_q;

        always_comb begin
            lane_d = lane_q;
            if (load_i) begin
                lane_d = data_i[b*BYTE_W +: BYTE_W];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '0;
            end else begin
                lane_q <= lane_d;
            end
        end

        assign bytes_o[b*BYTE_W +: BYTE_W] = lane_q;
    end

    // R5: without a load the stored set never moves.
    p_hold_without_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(bytes_o));

endmodule

// File: rtl/mag_result_guard.sv
module mag_result_guard
    import rgd_pkg::*;
#(
    parameter int unsigned N_BYTES     = 6,
    parameter int unsigned CLK_FREQ_HZ = 50_000_000,
    parameter int unsigned MIN_LOW_NS  = 5000
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_strobe_i,
    input  logic [N_BYTES*BYTE_W-1:0] wr_data_i,
    input  logic [N_BYTES-1:0]        rd_strobe_i,
    input  logic                      mode_chg_i,
    input  logic                      meas_chg_i,
    input  logic                      off_mode_i,
    input  logic                      ren_i,
    output logic [N_BYTES*BYTE_W-1:0] result_o,
    output logic [ST_W-1:0]           status_o,
    output logic                      drdy_o,
    output logic                      lost_o
);
    // Minimum low time in cycles, rounded up.
    localparam longint unsigned HOLD_L =
        (longint'(CLK_FREQ_HZ) * longint'(MIN_LOW_NS) + 64'd999_999_999) / 64'd1_000_000_000;
    localparam int unsigned HOLD_CYC = (HOLD_L == 0) ? 32'd1 : 32'(HOLD_L);
    localparam int unsigned CHK_W    = $clog2(HOLD_CYC + 1);

    logic cfg_change;
    logic accept;
    logic set_done;
    logic locked;
    logic rdy;

    assign cfg_change = mode_chg_i | meas_chg_i;

    rgd_read_tracker #(
        .N_BYTES (N_BYTES)
    ) u_tracker (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req_i     (wr_strobe_i),
        .rd_hit_i     (rd_strobe_i),
        .cfg_change_i (cfg_change),
        .accept_o     (accept),
        .set_done_o   (set_done),
        .locked_o     (locked),
        .lost_o       (lost_o)
    );

    rgd_result_store #(
        .N_BYTES (N_BYTES)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept),
        .data_i  (wr_data_i),
        .bytes_o (result_o)
    );

    rgd_ready_timer #(
        .HOLD_CYC (HOLD_CYC)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .drop_i (set_done),
        .off_i  (off_mode_i),
        .rdy_o  (rdy)
    );

    always_comb begin
        status_o               = '0;
        status_o[ST_READY_BIT] = rdy;
        status_o[ST_HOLD_BIT]  = locked;
        status_o[ST_REG_BIT]   = ren_i;
    end

    assign drdy_o = rdy;

    // Checker counter: cycles the ready pin has been low, saturating.
    logic [CHK_W-1:0] chk_low_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_low_run_q <= '0;
        end else if (drdy_o) begin
            chk_low_run_q <= '0;
        end else if (chk_low_run_q != CHK_W'(HOLD_CYC)) begin
            chk_low_run_q <= chk_low_run_q + 1'b1;
        end
    end

    // R6: the ready pin never rises before the minimum low time.
    p_min_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drdy_o) |-> (chk_low_run_q == CHK_W'(HOLD_CYC)));

    // R3 and R10: a locked write leaves the data and raises the lost pulse.
    p_drop_while_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe_i && status_o[ST_HOLD_BIT] && !cfg_change)
            |=> ($stable(result_o) && lost_o));

    // R4: a change pulse always unlocks.
    p_change_unlocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_change |=> !status_o[ST_HOLD_BIT]);

    // R5: an unlocked write is loaded and the flag is low.
    p_accept_loads_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe_i && (!status_o[ST_HOLD_BIT] || cfg_change))
            |=> ((result_o == $past(wr_data_i)) && !drdy_o && !lost_o));

endmodule

// File: tb/mag_result_guard_bench.sv
module mag_result_guard_bench;
    localparam int NB   = 6;
    localparam int HOLD = int'((64'd50_000_000 * 64'd5000 + 64'd999_999_999) / 64'd1_000_000_000);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_strobe_i = 1'b0;
    logic [NB*8-1:0] wr_data_i = '0;
    logic [NB-1:0]   rd_strobe_i = '0;
    logic            mode_chg_i = 1'b0;
    logic            meas_chg_i = 1'b0;
    logic            off_mode_i = 1'b0;
    logic            ren_i = 1'b0;
    logic [NB*8-1:0] result_o;
    logic [7:0]      status_o;
    logic            drdy_o;
    logic            lost_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    mag_result_guard u_mag_result_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_strobe_i (wr_strobe_i),
        .wr_data_i   (wr_data_i),
        .rd_strobe_i (rd_strobe_i),
        .mode_chg_i  (mode_chg_i),
        .meas_chg_i  (meas_chg_i),
        .off_mode_i  (off_mode_i),
        .ren_i       (ren_i),
        .result_o    (result_o),
        .status_o    (status_o),
        .drdy_o      (drdy_o),
        .lost_o      (lost_o)
    );

    function automatic logic [NB*8-1:0] pat(input int k);
        logic [NB*8-1:0] r;
        for (int b = 0; b < NB; b++) r[b*8 +: 8] = 8'(k * 13 + b * 37 + 5);
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Drive one cycle of stimulus; starts and ends at a falling edge.
    task automatic drive(input logic wr, input logic [NB*8-1:0] data, input logic [NB-1:0] rd,
                         input logic mch, input logic cch);
        wr_strobe_i = wr; wr_data_i = data; rd_strobe_i = rd;
        mode_chg_i = mch; meas_chg_i = cch;
        @(negedge clk);
        wr_strobe_i = 1'b0; rd_strobe_i = '0; mode_chg_i = 1'b0; meas_chg_i = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1 result", 64'(result_o), 64'h0);
        check("R1 status", 64'(status_o), 64'h0);
        check("R1 drdy", 64'(drdy_o), 64'h0);
        check("R1 lost", 64'(lost_o), 64'h0);

        // R9 regulator bit position
        ren_i = 1'b1; #1;
        check("R9 ren bit", 64'(status_o), 64'h04);
        ren_i = 1'b0;

        // R5 / R6 / R7 accepted write and ready timing
        drive(1'b1, pat(1), '0, 1'b0, 1'b0);
        check("R5 data loaded", 64'(result_o), 64'(pat(1)));
        check("R5 rdy low", 64'(drdy_o), 64'h0);
        idle(HOLD);
        check("R6 still low at MIN", 64'(drdy_o), 64'h0);
        idle(1);
        check("R6 high at MIN+1", 64'(drdy_o), 64'h1);
        check("R9 status ready", 64'(status_o), 64'h01);
        idle(20);
        check("R7 stays high", 64'(drdy_o), 64'h1);
        // R2 / R4 reads byte by byte, byte 0 twice
        drive(1'b0, '0, 6'b000001, 1'b0, 1'b0);
        check("R2 lock after one byte", 64'(status_o), 64'h03);
        drive(1'b0, '0, 6'b000001, 1'b0, 1'b0);
        for (int b = 1; b < NB - 1; b++) drive(1'b0, '0, 6'(1 << b), 1'b0, 1'b0);
        check("R4 repeat read counts once", 64'(status_o[1]), 64'h1);
        check("R7 high during partial read", 64'(drdy_o), 64'h1);
        drive(1'b0, '0, 6'b100000, 1'b0, 1'b0);
        check("R4 R7 unlocked and ready cleared", 64'(status_o), 64'h00);

        // R2 / R3 / R4 / R10 sweep over all proper read subsets
        for (int s = 1; s < 63; s++) begin
            drive(1'b1, pat(s), '0, 1'b0, 1'b0);
            check("R5 sweep load", 64'(result_o), 64'(pat(s)));
            drive(1'b0, '0, 6'(s), 1'b0, 1'b0);
            check("R2 sweep lock", 64'(status_o[1]), 64'h1);
            drive(1'b1, pat(s + 100), '0, 1'b0, 1'b0);
            check("R3 sweep held", 64'(result_o), 64'(pat(s)));
            check("R3 sweep lost", 64'(lost_o), 64'h1);
            idle(1);
            check("R3 lost one cycle", 64'(lost_o), 64'h0);
            if (s % 2 == 1) begin
                drive(1'b1, pat(s + 200), 6'(~s), 1'b0, 1'b0);
                check("R10 same-cycle write dropped", 64'(result_o), 64'(pat(s)));
                check("R10 lost", 64'(lost_o), 64'h1);
                check("R10 unlocked", 64'(status_o[1]), 64'h0);
            end else begin
                drive(1'b0, '0, 6'(~s), 1'b0, 1'b0);
                check("R4 sweep unlocked", 64'(status_o[1]), 64'h0);
            end
        end

        // R4 mode change unlocks
        drive(1'b1, pat(300), '0, 1'b0, 1'b0);
        drive(1'b0, '0, 6'b000100, 1'b0, 1'b0);
        check("R2 locked before mode change", 64'(status_o[1]), 64'h1);
        drive(1'b0, '0, '0, 1'b1, 1'b0);
        check("R4 mode change unlocks", 64'(status_o[1]), 64'h0);
        drive(1'b1, pat(301), '0, 1'b0, 1'b0);
        check("R5 load after mode change", 64'(result_o), 64'(pat(301)));
        // R4 config change with coincident write
        drive(1'b0, '0, 6'b001000, 1'b0, 1'b0);
        drive(1'b1, pat(302), '0, 1'b0, 1'b1);
        check("R4 write with change accepted", 64'(result_o), 64'(pat(302)));
        check("R4 no lost", 64'(lost_o), 64'h0);
        check("R4 unlocked", 64'(status_o[1]), 64'h0);

        // R8 off state
        idle(HOLD + 2);
        check("R6 ready before off", 64'(drdy_o), 64'h1);
        off_mode_i = 1'b1;
        idle(1);
        check("R8 off clears ready", 64'(drdy_o), 64'h0);
        drive(1'b1, pat(400), '0, 1'b0, 1'b0);
        check("R8 data still loads", 64'(result_o), 64'(pat(400)));
        idle(HOLD + 5);
        check("R8 held low while off", 64'(drdy_o), 64'h0);
        off_mode_i = 1'b0;
        idle(HOLD + 5);
        check("R8 pending cancelled", 64'(drdy_o), 64'h0);
        check("R9 drdy mirrors status", 64'(drdy_o), 64'(status_o[0]));

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule